// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA open-drain data) that fronts a small on-chip byte memory. Both bus lines are sampled by a faster system clock through a synchronizer. The block detects start and stop conditions and shifts address and data bytes in and out. It acknowledges the bytes it accepts by pulling SDA low through an output enable. SDA is never driven high.

A transaction opens with a start condition followed by a slave address byte. The upper nibble is the device type 1010. The next three bits must equal the strapped select inputs, and bit 0 gives the direction (1 = read, 0 = write). A write carries two address bytes and then any number of data bytes, each stored at once. A read streams bytes from the current internal address for as long as the master acknowledges. A write header followed by a repeated start and a read header therefore gives a random-address read. Start, stop and no-acknowledge each abandon whatever operation is in progress.

Top module: `tws_mem_slave`

## Requirements
- R1: After reset the slave keeps SDA released (sda_oe = 0) and ignores every bit clocked before the first start condition, so it does not acknowledge them.
- R2: A start condition (SDA falling while SCL is high) aborts any operation in progress, including a partly received data byte, which is not stored. The next byte is taken as a slave address.
- R3: A stop condition (SDA rising while SCL is high) abandons the current operation: a partly received byte is not stored, and later bytes are not acknowledged until a new start.
- R4: A slave address byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal sel_i. Otherwise the slave stays silent (sda_oe = 0) for the rest of that transaction.
- R5: The slave pulls SDA low during the ninth clock of every byte it accepts: a matching address, both memory address bytes, and every write data byte.
- R6: In a write, the byte after the slave address is the high address byte and the next one is the low byte. Only the low ADDR_W bits of {high,low} are used (ADDR_W = 10 by default, so the upper 6 bits are ignored). Each following data byte is stored at the current address.
- R7: In a read, slave address bit 0 = 1. The slave sends bytes MSB first from the current address and continues while the master acknowledges. A master no-acknowledge ends the read and the slave releases SDA.
- R8: The internal address increments after every byte written or read, and wraps from 2^ADDR_W - 1 to 0.
- R9: A read that is not preceded by an address write in the same transaction starts at the address left by the previous operation.
- R10: sda_oe changes only while the synchronized SCL is low. SDA is only ever pulled low, never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sel_i | input | 3 | Strapped select bits compared with address bits 3..1 |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench tries the main function with several patterns. Sequential writes followed by a random-address read separate correct address loading from simple streaming. A current-address read after a shorter write separates a freshly loaded address from one left over by an earlier access. A write and read across the top location show whether the address wraps. Address bytes with junk in the ignored upper bits show whether those bits are dropped. Headers with a wrong device type or wrong select bits, bytes clocked with no start, and stop or start arriving in the middle of a data byte each check that the block stays silent or discards the partial byte. A bus-level watch confirms that the enable only moves while SCL is low.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_MACK
    } bus_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } rx_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        bus_state_e state;
        rx_kind_e   kind;
        logic [2:0] bitcnt;
        logic       done;
        logic [7:0] rx_sh;
        logic [7:0] tx_sh;
        logic [7:0] hi_byte;
        logic       rw;
        logic       mack;
        logic       oe;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        state:   S_IDLE,
        kind:    K_DEV,
        bitcnt:  3'd0,
        done:    1'b0,
        rx_sh:   8'h00,
        tx_sh:   8'h00,
        hi_byte: 8'h00,
        rw:      1'b0,
        mack:    1'b0,
        oe:      1'b0
    };

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == sel);
    endfunction

    function automatic rx_kind_e next_kind(input rx_kind_e k);
        case (k)
            K_DEV:   return K_AHI;
            K_AHI:   return K_ALO;
            default: return K_DATA;
        endcase
    endfunction

endpackage

// File: rtl/tws_bus_sync.sv
module tws_bus_sync
    import tws_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= scl_i;
                    sda_p <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_p <= '1;
                    sda_p <= '1;
                end else begin
                    scl_p <= {scl_p[STAGES-2:0], scl_i};
                    sda_p <= {sda_p[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_p[STAGES-1];
            sda_q <= sda_p[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_p[STAGES-1];
        ev.sda      = sda_p[STAGES-1];
        ev.scl_rise = scl_p[STAGES-1] & ~scl_q;
        ev.scl_fall = ~scl_p[STAGES-1] & scl_q;
        ev.start    = scl_p[STAGES-1] & scl_q & sda_q & ~sda_p[STAGES-1];
        ev.stop     = scl_p[STAGES-1] & scl_q & ~sda_q & sda_p[STAGES-1];
    end

endmodule

// File: rtl/tws_byte_ram.sv
module tws_byte_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/tws_addr_ctr.sv
module tws_addr_ctr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)      addr <= '0;
        else if (ld)  addr <= ld_val;
        else if (inc) addr <= addr + 1'b1;
    end

endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
    import tws_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_i,
    output logic       sda_oe
);
    bus_ev_t           ev;
    ctl_t              cur, nxt;
    logic              we, inc, ld;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] ld_val;
    logic [7:0]        rdata;
    logic              accept;

    tws_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    tws_addr_ctr #(.AW(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld),
        .ld_val (ld_val),
        .inc    (inc),
        .addr   (addr)
    );

    tws_byte_ram #(.AW(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (addr),
        .wdata (cur.rx_sh),
        .raddr (addr),
        .rdata (rdata)
    );

    assign ld_val = ADDR_W'({cur.hi_byte, cur.rx_sh});

    always_comb begin
        nxt    = cur;
        we     = 1'b0;
        inc    = 1'b0;
        ld     = 1'b0;
        accept = 1'b0;
        if (ev.start) begin
            nxt.state  = S_RX;
            nxt.kind   = K_DEV;
            nxt.bitcnt = 3'd0;
            nxt.done   = 1'b0;
            nxt.mack   = 1'b0;
            nxt.oe     = 1'b0;
        end else if (ev.stop) begin
            nxt.state = S_IDLE;
            nxt.oe    = 1'b0;
        end else begin
            case (cur.state)
                S_RX: begin
                    if (ev.scl_rise && !cur.done) begin
                        nxt.rx_sh  = {cur.rx_sh[6:0], ev.sda};
                        nxt.bitcnt = 3'(cur.bitcnt + 3'd1);
                        if (cur.bitcnt == 3'd7) nxt.done = 1'b1;
                    end else if (ev.scl_fall && cur.done) begin
                        nxt.done   = 1'b0;
                        nxt.bitcnt = 3'd0;
                        accept     = 1'b1;
                        case (cur.kind)
                            K_DEV: begin
                                accept = dev_match(cur.rx_sh, sel_i);
                                nxt.rw = cur.rx_sh[0];
                            end
                            K_AHI:   nxt.hi_byte = cur.rx_sh;
                            K_ALO:   ld = 1'b1;
                            default: begin
                                we  = 1'b1;
                                inc = 1'b1;
                            end
                        endcase
                        if (accept) begin
                            nxt.state = S_ACK;
                            nxt.oe    = 1'b1;
                        end else begin
                            nxt.state = S_IDLE;
                        end
                    end
                end
                S_ACK: begin
                    if (ev.scl_fall) begin
                        nxt.oe = 1'b0;
                        if (cur.kind == K_DEV && cur.rw) begin
                            nxt.state  = S_TX;
                            nxt.tx_sh  = rdata;
                            nxt.bitcnt = 3'd0;
                            nxt.oe     = ~rdata[7];
                            inc        = 1'b1;
                        end else begin
                            nxt.state = S_RX;
                            nxt.kind  = next_kind(cur.kind);
                        end
                    end
                end
                S_TX: begin
                    if (ev.scl_fall) begin
                        nxt.bitcnt = 3'(cur.bitcnt + 3'd1);
                        if (cur.bitcnt == 3'd7) begin
                            nxt.state = S_MACK;
                            nxt.oe    = 1'b0;
                            nxt.mack  = 1'b0;
                        end else begin
                            nxt.tx_sh = {cur.tx_sh[6:0], 1'b0};
                            nxt.oe    = ~cur.tx_sh[6];
                        end
                    end
                end
                S_MACK: begin
                    if (ev.scl_rise) begin
                        if (ev.sda) nxt.state = S_IDLE;
                        else        nxt.mack  = 1'b1;
                    end else if (ev.scl_fall && cur.mack) begin
                        nxt.mack   = 1'b0;
                        nxt.state  = S_TX;
                        nxt.tx_sh  = rdata;
                        nxt.bitcnt = 3'd0;
                        nxt.oe     = ~rdata[7];
                        inc        = 1'b1;
                    end
                end
                default: nxt.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= CTL_RESET;
        else     cur <= nxt;
    end

    assign sda_oe = cur.oe;

    // R1: no pull-down while the slave is not addressed
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (cur.state == S_IDLE) |-> !sda_oe);

    // R2: a start always returns to address reception
    a_r2_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (cur.state == S_RX && cur.kind == K_DEV && cur.bitcnt == 3'd0 && !sda_oe));

    // R3: a stop always abandons the operation
    a_r3_stop_idle: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !ev.start) |=> (cur.state == S_IDLE && !sda_oe));

    // R5: the acknowledge slot is driven low
    a_r5_ack_low: assert property (@(posedge clk) disable iff (rst)
        (cur.state == S_ACK) |-> sda_oe);

    // R7: line released while the master answers
    a_r7_mack_released: assert property (@(posedge clk) disable iff (rst)
        (cur.state == S_MACK) |-> !sda_oe);

    // R10: enable moves only while SCL is low
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (rst || ev.start || ev.stop)
        !$stable(sda_oe) |-> !ev.scl);

endmodule

// File: tb/tws_mem_slave_test.sv
module tws_mem_slave_test;

    localparam int Q = 10;

    typedef struct {
        string req;
        int    val;
        string what;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] sel = 3'b101;
    logic       sda_oe;
    wire        sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int oe_cnt = 0;
    int r10_viol = 0;
    bit finished = 0;
    item_t exp_q[$];
    int    obs_q[$];

    always #10 clk = ~clk;

    tws_mem_slave uut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sel_i  (sel),
        .sda_oe (sda_oe)
    );

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (obs_q.size() > 0 && exp_q.size() > 0) begin
            item_t e;
            int    o;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            check(e.req, o, e.val, e.what);
        end
    end

    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (sda_oe) oe_cnt++;
        if (sda_oe !== oe_prev && scl) r10_viol++;
        oe_prev = sda_oe;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_out(logic b);
        wq(); sda_m = b;
        wq(); scl = 1'b1;
        wq(); wq(); scl = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        wq(); sda_m = 1'b1;
        wq(); scl = 1'b1;
        wq(); b = sda_bus;
        wq(); scl = 1'b0;
    endtask

    task automatic do_start();
        wq(); sda_m = 1'b1;
        wq(); scl = 1'b1;
        wq(); sda_m = 1'b0;
        wq(); scl = 1'b0;
    endtask

    task automatic do_stop();
        wq(); sda_m = 1'b0;
        wq(); scl = 1'b1;
        wq(); sda_m = 1'b1;
        wq();
    endtask

    // driver: send a byte and expect the ack level (0 = ack)
    task automatic send_byte(logic [7:0] b, bit ack, string req, string what);
        logic a;
        exp_q.push_back('{req, ack ? 0 : 1, what});
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        obs_q.push_back(int'(a));
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) bit_out(b[i]);
    endtask

    task automatic recv_byte(logic [7:0] exp, bit master_ack, string req, string what);
        logic [7:0] v;
        logic       b;
        exp_q.push_back('{req, int'(exp), what});
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        obs_q.push_back(int'(v));
        bit_out(master_ack ? 1'b0 : 1'b1);
    endtask

    localparam logic [7:0] WR = 8'hAA;
    localparam logic [7:0] RD = 8'hAB;

    initial begin
        int c0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", int'(sda_oe), 0, "released after reset");

        // R1: bytes before any start are ignored
        wq(); scl = 1'b0;
        c0 = oe_cnt;
        send_byte(WR, 1'b0, "R1", "no ack before first start");
        check("R1", oe_cnt - c0, 0, "no pull-down before start");

        // R6/R5: sequential write at 0x010, upper address bits junk
        do_start();
        send_byte(WR, 1'b1, "R4", "matching header acked");
        send_byte(8'hFC, 1'b1, "R5", "high address acked");
        send_byte(8'h10, 1'b1, "R5", "low address acked");
        send_byte(8'h11, 1'b1, "R6", "data0 acked");
        send_byte(8'h22, 1'b1, "R6", "data1 acked");
        send_byte(8'h33, 1'b1, "R6", "data2 acked");
        do_stop();

        // R7: random read through repeated start
        do_start();
        send_byte(WR, 1'b1, "R4", "header acked");
        send_byte(8'h00, 1'b1, "R5", "high address acked");
        send_byte(8'h10, 1'b1, "R5", "low address acked");
        do_start();
        send_byte(RD, 1'b1, "R7", "read header acked");
        recv_byte(8'h11, 1'b1, "R7", "read byte0");
        recv_byte(8'h22, 1'b1, "R7", "read byte1");
        recv_byte(8'h33, 1'b0, "R7", "read byte2");
        repeat (4) @(negedge clk);
        check("R7", int'(sda_oe), 0, "released after master nack");
        do_stop();

        // R9: current-address read
        do_start();
        send_byte(WR, 1'b1, "R9", "header");
        send_byte(8'h00, 1'b1, "R9", "addr hi");
        send_byte(8'h10, 1'b1, "R9", "addr lo");
        send_byte(8'h44, 1'b1, "R9", "overwrite 0x010");
        do_stop();
        do_start();
        send_byte(RD, 1'b1, "R9", "read header");
        recv_byte(8'h22, 1'b0, "R9", "current address 0x011");
        do_stop();

        // R8: wrap at top of memory
        do_start();
        send_byte(WR, 1'b1, "R8", "header");
        send_byte(8'h03, 1'b1, "R8", "addr hi");
        send_byte(8'hFE, 1'b1, "R8", "addr lo");
        send_byte(8'hA1, 1'b1, "R8", "data at 0x3FE");
        send_byte(8'hA2, 1'b1, "R8", "data at 0x3FF");
        send_byte(8'hA3, 1'b1, "R8", "data at 0x000");
        do_stop();
        do_start();
        send_byte(WR, 1'b1, "R6", "header");
        send_byte(8'hFF, 1'b1, "R6", "addr hi upper junk");
        send_byte(8'hFE, 1'b1, "R6", "addr lo");
        do_start();
        send_byte(RD, 1'b1, "R8", "read header");
        recv_byte(8'hA1, 1'b1, "R6", "upper bits ignored");
        recv_byte(8'hA2, 1'b1, "R8", "top location");
        recv_byte(8'hA3, 1'b0, "R8", "wrapped to 0");
        do_stop();

        // R4: mismatching headers stay silent
        c0 = oe_cnt;
        do_start();
        send_byte(8'hA8, 1'b0, "R4", "wrong select nacked");
        send_byte(8'h00, 1'b0, "R4", "following byte ignored");
        do_stop();
        do_start();
        send_byte(8'hBA, 1'b0, "R4", "wrong device type nacked");
        do_stop();
        check("R4", oe_cnt - c0, 0, "no pull-down on mismatch");

        // R3: stop mid-byte discards it
        do_start();
        send_byte(WR, 1'b1, "R3", "header");
        send_byte(8'h00, 1'b1, "R3", "addr hi");
        send_byte(8'h20, 1'b1, "R3", "addr lo");
        send_byte(8'h55, 1'b1, "R3", "data 0x020");
        send_byte(8'h99, 1'b1, "R3", "data 0x021");
        do_stop();
        do_start();
        send_byte(WR, 1'b1, "R3", "header");
        send_byte(8'h00, 1'b1, "R3", "addr hi");
        send_byte(8'h21, 1'b1, "R3", "addr lo");
        send_bits(8'h66, 4);
        do_stop();
        wq(); scl = 1'b0;
        send_byte(RD, 1'b0, "R3", "no ack after stop without start");

        // R2: start mid-byte aborts, then current-address read
        do_start();
        send_byte(WR, 1'b1, "R2", "header");
        send_byte(8'h00, 1'b1, "R2", "addr hi");
        send_byte(8'h21, 1'b1, "R2", "addr lo");
        send_bits(8'h66, 3);
        do_start();
        send_byte(RD, 1'b1, "R2", "header after abort");
        recv_byte(8'h99, 1'b0, "R2", "partial byte not stored (R3 too)");
        do_stop();

        repeat (20) @(negedge clk);
        check("R10", r10_viol, 0, "enable changes with SCL high");
        check("R5", exp_q.size(), 0, "scoreboard drained");
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule